// File: doc/BRIEF.md
# Half-Duplex SPI Transaction Engine

This block is a memory-mapped SPI master that runs one half-duplex transaction for each start command. Software loads up to eight outbound bytes into two 32-bit holding words, the command word and the data word. It writes a transmit count and a receive count to the control word, then sets the start bit. The engine shifts the outbound bytes out MSB-first in SPI mode 0. With no gap after the last outbound bit, it clocks in the requested number of response bytes and writes them back into the same two holding words.

The byte-to-lane mapping is fixed and is not linear. Outbound byte 0 is the low byte of the command word. Outbound bytes 1 to 3 are the command word's upper bytes, taken from the top down. Outbound bytes 4 to 7 are the data word's bytes, taken from the bottom up. Response bytes fill the data word first, low byte to high byte, and then the command word in the same way.

The SCK rate comes from a divider field in the configuration word. The single slave select is a software-controlled bit, and it holds its level across transactions. Software polls the busy bit in the control word to learn when a transaction has finished.

Top module: `spi_xact_engine`

## Requirements
- R1: After reset the control word reads 0 and the configuration word reads 0x0003_0000. spi_ss is high (released), spi_sck is low and spi_mosi is low.
- R2: The register offsets are: control 0x00, command 0x04, data 0x08, configuration 0x28, select 0x38 and spacing 0x3C. Configuration, command, data and spacing read back all 32 written bits. The spacing word is storage only. The select word keeps only bit 0, and its other bits read 0. The control word reads back its written bits [7:0]. Its bit 8 reads 0, and bit 16 is the busy flag.
- R3: A control write with bit 8 set, made while idle, starts a transaction. The transmit count comes from bits [3:0] of the written value and the receive count from bits [7:4]. Busy reads 1 in the cycle after the write and returns to 0 once the last bit is done.
- R4: Outbound byte order is: command[7:0], command[31:24], command[23:16], command[15:8], data[7:0], data[15:8], data[23:16], data[31:24].
- R5: Response byte j (j = 0..7) is written to data[8j+7:8j] for j < 4 and to command[8(j-4)+7:8(j-4)] for j >= 4. Lanes beyond the receive count keep their previous value.
- R6: SPI mode 0, MSB-first. SCK idles low. MOSI changes only while SCK is low, so it holds steady through each high phase. MISO is sampled at each SCK rising edge.
- R7: The SCK period equals (divider + 2) system clocks, where the divider is configuration bits [27:16]. The high phase lasts floor((divider+2)/2) clocks.
- R8: A transaction produces exactly 8 × (tx + rx) SCK rising edges, with the read phase following the write phase directly. A count above 8 is treated as 8.
- R9: A start written while busy is ignored. The running transaction is not restarted, and the stored counts do not change.
- R10: With both counts zero, no SCK edge occurs and busy is high for exactly one cycle.
- R11: Select bit 1 drives spi_ss low and bit 0 drives it high. The level holds through and between transactions.
- R12: Any bus write made while busy is ignored. This covers the command, data and configuration words.
- R13: A transaction with a receive count of zero leaves the command and data words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_ss | output | 1 | Slave select, active low by default |

## Verification
The bench goes after each corner case and names the failure it would expose:
- Odd and even divide ratios, including the minimum of two clocks. A design that split the SCK period wrongly would produce an off-by-one period or high phase.
- The junction between the write and read phases. An engine that inserted a turnaround bit, or dropped one, would give a wrong edge count and shifted response bytes.
- A zero/zero start. A design that ran a bit anyway would show a stray SCK edge or a busy pulse that is too long.
- Counts above eight. Without clamping, the engine would keep clocking past the holding words.
- A restart and register writes issued in the middle of a transaction. A design that accepted them would show the wrong edge count or clobbered words.
- Partial receive counts. A design that cleared unused lanes would lose bytes that should have survived.

// File: rtl/spi_xact_pkg.sv
package spi_xact_pkg;
   localparam int REG_W         = 32;
   localparam int LANE_W        = 8;
   localparam int LANES         = 8;

   // register byte offsets
   localparam logic [7:0] OFS_CTRL = 8'h00;
   localparam logic [7:0] OFS_CMD  = 8'h04;
   localparam logic [7:0] OFS_DATA = 8'h08;
   localparam logic [7:0] OFS_CFG  = 8'h28;
   localparam logic [7:0] OFS_SEL  = 8'h38;
   localparam logic [7:0] OFS_GAP  = 8'h3C;

   // control word fields
   localparam int CTRL_GO_BIT   = 8;
   localparam int CTRL_BUSY_BIT = 16;
   localparam int CFG_DIV_LSB   = 16;

   typedef enum logic {
      SEQ_IDLE  = 1'b0,
      SEQ_SHIFT = 1'b1
   } seq_state_t;
endpackage

// File: rtl/spi_xact_regs.sv
module spi_xact_regs
   import spi_xact_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int DIV_W   = 12,
   parameter int DIV_RST = 3,
   parameter int CNT_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [REG_W-1:0]  bus_wdata,
   output logic [REG_W-1:0]  bus_rdata,
   input  logic              busy,
   input  logic              lane_we,
   input  logic [2:0]        lane_idx,
   input  logic [LANE_W-1:0] lane_val,
   output logic              go,
   output logic [CNT_W-1:0]  go_tx,
   output logic [CNT_W-1:0]  go_rx,
   output logic [REG_W-1:0]  cmd_word,
   output logic [REG_W-1:0]  data_word,
   output logic [DIV_W-1:0]  div,
   output logic              sel
);
   localparam logic [REG_W-1:0] CFG_RST = REG_W'(DIV_RST) << CFG_DIV_LSB;

   if (CNT_W != 4) begin : g_bad_cnt
      $error("spi_xact_regs: CNT_W must be 4");
   end
   if (DIV_W < 1 || DIV_W > 12) begin : g_bad_div
      $error("spi_xact_regs: DIV_W must be 1..12");
   end

   logic [2*CNT_W-1:0] cnt_q;
   logic [REG_W-1:0]   cfg_q;
   logic [REG_W-1:0]   gap_q;
   logic               hit_ctrl, hit_cmd, hit_data, hit_cfg, hit_sel, hit_gap;
   logic               wr_ok;

   assign hit_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
   assign hit_cmd  = (bus_addr == ADDR_W'(OFS_CMD));
   assign hit_data = (bus_addr == ADDR_W'(OFS_DATA));
   assign hit_cfg  = (bus_addr == ADDR_W'(OFS_CFG));
   assign hit_sel  = (bus_addr == ADDR_W'(OFS_SEL));
   assign hit_gap  = (bus_addr == ADDR_W'(OFS_GAP));
   assign wr_ok    = bus_wr && !busy;

   assign go    = wr_ok && hit_ctrl && bus_wdata[CTRL_GO_BIT];
   assign go_tx = bus_wdata[CNT_W-1:0];
   assign go_rx = bus_wdata[2*CNT_W-1:CNT_W];
   assign div   = cfg_q[CFG_DIV_LSB +: DIV_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         cmd_word  <= '0;
         data_word <= '0;
         cfg_q     <= CFG_RST;
         gap_q     <= '0;
         sel       <= 1'b0;
      end else if (wr_ok) begin
         if (hit_ctrl) cnt_q     <= bus_wdata[2*CNT_W-1:0];
         if (hit_cmd)  cmd_word  <= bus_wdata;
         if (hit_data) data_word <= bus_wdata;
         if (hit_cfg)  cfg_q     <= bus_wdata;
         if (hit_sel)  sel       <= bus_wdata[0];
         if (hit_gap)  gap_q     <= bus_wdata;
      end else if (lane_we) begin
         if (lane_idx[2]) cmd_word[{lane_idx[1:0], 3'b000} +: LANE_W]  <= lane_val;
         else             data_word[{lane_idx[1:0], 3'b000} +: LANE_W] <= lane_val;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (hit_ctrl) begin
         bus_rdata[2*CNT_W-1:0]    = cnt_q;
         bus_rdata[CTRL_BUSY_BIT]  = busy;
      end else if (hit_cmd)  bus_rdata = cmd_word;
      else if (hit_data)     bus_rdata = data_word;
      else if (hit_cfg)      bus_rdata = cfg_q;
      else if (hit_sel)      bus_rdata[0] = sel;
      else if (hit_gap)      bus_rdata = gap_q;
   end

   AST_HOLD_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !lane_we) |=> ($stable(cmd_word) && $stable(data_word))); // R12
   AST_HOLD_CFG: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(div)); // R12
   AST_HOLD_CNT: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(cnt_q)); // R9
endmodule

// File: rtl/spi_xact_sckgen.sv
module spi_xact_sckgen #(
   parameter int RATIO_W = 13
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic [RATIO_W-1:0] ratio,
   output logic               rise_tick,
   output logic               fall_tick
);
   if (RATIO_W < 2) begin : g_bad_ratio
      $error("spi_xact_sckgen: RATIO_W must be at least 2");
   end

   logic [RATIO_W-1:0] cnt_q;
   logic [RATIO_W-1:0] low_len;

   // low phase takes the larger half of an odd ratio
   assign low_len   = ratio - (ratio >> 1);
   assign rise_tick = run && (cnt_q == low_len - RATIO_W'(1));
   assign fall_tick = run && (cnt_q == ratio - RATIO_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt_q <= '0;
      else if (!run || fall_tick)  cnt_q <= '0;
      else                         cnt_q <= cnt_q + RATIO_W'(1);
   end

   AST_TICKS_APART: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise_tick && fall_tick)); // R7
   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q < ratio)); // R7
endmodule

// File: rtl/spi_xact_seq.sv
module spi_xact_seq
   import spi_xact_pkg::*;
#(
   parameter int BYTES   = 8,
   parameter int CNT_W   = 4,
   parameter int RATIO_W = 13
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               go,
   input  logic [CNT_W-1:0]   go_tx,
   input  logic [CNT_W-1:0]   go_rx,
   input  logic [REG_W-1:0]   cmd_word,
   input  logic [REG_W-1:0]   data_word,
   input  logic [RATIO_W-1:0] ratio_in,
   input  logic               miso,
   input  logic               rise_tick,
   input  logic               fall_tick,
   output logic               run,
   output logic [RATIO_W-1:0] ratio,
   output logic               busy,
   output logic               sck,
   output logic               mosi,
   output logic               lane_we,
   output logic [2:0]         lane_idx,
   output logic [LANE_W-1:0]  lane_val
);
   localparam int VEC_W = BYTES * LANE_W;
   localparam int TOT_W = $clog2(2 * BYTES * LANE_W + 1);

   if (BYTES != LANES) begin : g_bad_bytes
      $error("spi_xact_seq: BYTES must equal the fixed lane count");
   end

   function automatic logic [CNT_W-1:0] clamp_cnt(input logic [CNT_W-1:0] c);
      return (c > CNT_W'(BYTES)) ? CNT_W'(BYTES) : c;
   endfunction

   seq_state_t         state_q;
   logic [TOT_W-1:0]   tx_bits_q, tot_bits_q, bidx_q, rx_pos;
   logic [VEC_W-1:0]   txv_q;
   logic [LANE_W-2:0]  rxsh_q;
   logic               in_tx;
   logic [LANE_W-1:0]  rx_byte;

   assign busy    = (state_q == SEQ_SHIFT);
   assign run     = busy && (tot_bits_q != '0);
   assign in_tx   = bidx_q < tx_bits_q;
   assign rx_pos  = bidx_q - tx_bits_q;
   assign rx_byte = {rxsh_q, miso};
   assign mosi    = (busy && in_tx) ? txv_q[VEC_W-1] : 1'b0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= SEQ_IDLE;
         tx_bits_q  <= '0;
         tot_bits_q <= '0;
         bidx_q     <= '0;
         txv_q      <= '0;
         rxsh_q     <= '0;
         ratio      <= RATIO_W'(2);
         sck        <= 1'b0;
         lane_we    <= 1'b0;
         lane_idx   <= '0;
         lane_val   <= '0;
      end else begin
         lane_we <= 1'b0;
         if (!busy) begin
            if (go) begin
               state_q    <= SEQ_SHIFT;
               bidx_q     <= '0;
               sck        <= 1'b0;
               ratio      <= ratio_in;
               tx_bits_q  <= TOT_W'({clamp_cnt(go_tx), 3'b000});
               tot_bits_q <= TOT_W'({clamp_cnt(go_tx), 3'b000})
                           + TOT_W'({clamp_cnt(go_rx), 3'b000});
               txv_q      <= {cmd_word[7:0],   cmd_word[31:24],
                              cmd_word[23:16], cmd_word[15:8],
                              data_word[7:0],  data_word[15:8],
                              data_word[23:16], data_word[31:24]};
            end
         end else if (tot_bits_q == '0) begin
            state_q <= SEQ_IDLE;
         end else begin
            if (rise_tick) begin
               sck <= 1'b1;
               if (!in_tx) begin
                  rxsh_q <= rx_byte[LANE_W-2:0];
                  if (rx_pos[2:0] == 3'd7) begin
                     lane_we  <= 1'b1;
                     lane_idx <= 3'(rx_pos >> 3);
                     lane_val <= rx_byte;
                  end
               end
            end
            if (fall_tick) begin
               sck <= 1'b0;
               if (in_tx) txv_q <= txv_q << 1;
               if (bidx_q == tot_bits_q - TOT_W'(1)) state_q <= SEQ_IDLE;
               else                                  bidx_q  <= bidx_q + TOT_W'(1);
            end
         end
      end
   end

   AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sck); // R6
   AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (sck && $past(sck)) |-> $stable(mosi)); // R6
   AST_ZERO_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !run) |=> !busy); // R10
   AST_BIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (bidx_q < tot_bits_q)); // R8
   AST_LANE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      lane_we |-> (TOT_W'({lane_idx, 3'b000}) < tot_bits_q - tx_bits_q)); // R5
endmodule

// File: rtl/spi_xact_engine.sv
module spi_xact_engine
   import spi_xact_pkg::*;
#(
   parameter int ADDR_W        = 8,
   parameter int DIV_W         = 12,
   parameter int DIV_RST       = 3,
   parameter bit SS_ACTIVE_LOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              spi_sck,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic              spi_ss
);
   localparam int CNT_W   = 4;
   localparam int RATIO_W = DIV_W + 1;

   if (ADDR_W < 8) begin : g_bad_addr
      $error("spi_xact_engine: ADDR_W must be at least 8");
   end

   logic               busy, go, sel, run, rise_tick, fall_tick;
   logic               lane_we;
   logic [2:0]         lane_idx;
   logic [LANE_W-1:0]  lane_val;
   logic [CNT_W-1:0]   go_tx, go_rx;
   logic [REG_W-1:0]   cmd_word, data_word;
   logic [DIV_W-1:0]   div;
   logic [RATIO_W-1:0] ratio_in, ratio;

   assign ratio_in = RATIO_W'(div) + RATIO_W'(2);

   spi_xact_regs #(
      .ADDR_W(ADDR_W), .DIV_W(DIV_W), .DIV_RST(DIV_RST), .CNT_W(CNT_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .busy(busy), .lane_we(lane_we), .lane_idx(lane_idx), .lane_val(lane_val),
      .go(go), .go_tx(go_tx), .go_rx(go_rx),
      .cmd_word(cmd_word), .data_word(data_word), .div(div), .sel(sel)
   );

   spi_xact_sckgen #(.RATIO_W(RATIO_W)) u_sckgen (
      .clk(clk), .rst_n(rst_n), .run(run), .ratio(ratio),
      .rise_tick(rise_tick), .fall_tick(fall_tick)
   );

   spi_xact_seq #(.BYTES(LANES), .CNT_W(CNT_W), .RATIO_W(RATIO_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .go(go), .go_tx(go_tx), .go_rx(go_rx),
      .cmd_word(cmd_word), .data_word(data_word), .ratio_in(ratio_in),
      .miso(spi_miso), .rise_tick(rise_tick), .fall_tick(fall_tick),
      .run(run), .ratio(ratio), .busy(busy), .sck(spi_sck), .mosi(spi_mosi),
      .lane_we(lane_we), .lane_idx(lane_idx), .lane_val(lane_val)
   );

   if (SS_ACTIVE_LOW) begin : g_ss_low
      assign spi_ss = ~sel;
   end else begin : g_ss_high
      assign spi_ss = sel;
   end

   AST_SS_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(spi_ss)); // R11
endmodule

// File: tb/sim_spi_xact_engine.sv
`timescale 1ns/1ps
module sim_spi_xact_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        spi_sck, spi_mosi, spi_ss;
   logic        spi_miso = 1'b0;

   int n_cmp = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   spi_xact_engine u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_ss(spi_ss)
   );

   // ---------------- slave model ----------------
   logic [7:0] resp [16];
   logic [7:0] cap  [16];
   int         rises = 0;
   realtime    last_rise = 0.0;
   int         per_min, per_max, hi_min, hi_max;

   always @(posedge spi_sck) begin
      if (rises < 128) cap[rises >> 3][7 - (rises & 7)] = spi_mosi;
      if (rises > 0) begin
         int p;
         p = int'(($realtime - last_rise) / 5.0);
         if (p < per_min) per_min = p;
         if (p > per_max) per_max = p;
      end
      last_rise = $realtime;
      rises = rises + 1;
   end

   always @(negedge spi_sck) begin
      if (rises > 0) begin
         int h;
         h = int'(($realtime - last_rise) / 5.0);
         if (h < hi_min) hi_min = h;
         if (h > hi_max) hi_max = h;
      end
      if (rises < 128) spi_miso <= resp[rises >> 3][7 - (rises & 7)];
   end

   // ---------------- helpers ----------------
   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   function automatic logic [7:0] tx_byte(input logic [31:0] op, input logic [31:0] dt, input int i);
      case (i)
         0: return op[7:0];
         1: return op[31:24];
         2: return op[23:16];
         3: return op[15:8];
         4: return dt[7:0];
         5: return dt[15:8];
         6: return dt[23:16];
         default: return dt[31:24];
      endcase
   endfunction

   task automatic wait_idle(input string tag);
      logic [31:0] r;
      int guard = 0;
      bus_read(8'h00, r);
      while (r[16] && guard < 20000) begin
         @(negedge clk);
         bus_read(8'h00, r);
         guard++;
      end
      check({tag, " busy clears"}, {31'b0, r[16]}, 32'd0);
   endtask

   // meddle: issue a restart and register writes while busy
   task automatic run_xact(input logic [31:0] op, input logic [31:0] dt,
                           input int txc, input int rxc, input int dv, input bit meddle);
      logic [31:0] r, e_op, e_dt;
      int tc, rc, n;
      tc = (txc > 8) ? 8 : txc;
      rc = (rxc > 8) ? 8 : rxc;
      n  = dv + 2;
      for (int i = 0; i < 16; i++) resp[i] = 8'($urandom);
      bus_write(8'h28, (32'(dv) << 16) | (32'h7 << 29));
      bus_write(8'h04, op);
      bus_write(8'h08, dt);
      bus_write(8'h00, {24'b0, 4'(rxc), 4'(txc)});
      rises = 0; per_min = 1 << 30; per_max = 0; hi_min = 1 << 30; hi_max = 0;
      spi_miso = resp[0][7];
      bus_write(8'h00, {23'b0, 1'b1, 4'(rxc), 4'(txc)});
      bus_read(8'h00, r);
      check("R3 busy next cycle", {31'b0, r[16]}, 32'd1);
      if (meddle) begin
         bus_write(8'h00, 32'h0000_0188);         // restart attempt
         bus_write(8'h04, 32'hDEAD_BEEF);
         bus_write(8'h08, 32'hFACE_0FF0);
         bus_write(8'h28, 32'h0005_0000);
      end
      wait_idle("R3");
      check("R8 edge count", 32'(rises), 32'(8 * (tc + rc)));
      for (int i = 0; i < tc; i++)
         check($sformatf("R4 R6 tx byte %0d", i), {24'b0, cap[i]}, {24'b0, tx_byte(op, dt, i)});
      if (tc + rc > 1) begin
         check("R7 period min", 32'(per_min), 32'(n));
         check("R7 period max", 32'(per_max), 32'(n));
         check("R7 high time", 32'(hi_max), 32'(n / 2));
      end
      e_op = op; e_dt = dt;
      for (int j = 0; j < rc; j++) begin
         if (j < 4) e_dt[8*j +: 8]     = resp[tc + j];
         else       e_op[8*(j-4) +: 8] = resp[tc + j];
      end
      bus_read(8'h04, r);
      check(rc == 0 ? "R13 cmd kept" : "R5 cmd lanes", r, e_op);
      bus_read(8'h08, r);
      check(rc == 0 ? "R13 data kept" : "R5 data lanes", r, e_dt);
      if (meddle) begin
         bus_read(8'h00, r);
         check("R9 counts kept", r, {24'b0, 4'(rxc), 4'(txc)});
         bus_read(8'h28, r);
         check("R12 cfg kept", r, (32'(dv) << 16) | (32'h7 << 29));
      end
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(200000 * 5);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      logic [31:0] r;
      void'($urandom(32'd4711));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      bus_read(8'h00, r); check("R1 ctrl reset", r, 32'h0);
      bus_read(8'h28, r); check("R1 cfg reset", r, 32'h0003_0000);
      check("R1 ss released", {31'b0, spi_ss}, 32'd1);
      check("R1 sck low", {31'b0, spi_sck}, 32'd0);
      check("R1 mosi low", {31'b0, spi_mosi}, 32'd0);

      // R2 register map readback
      bus_write(8'h3C, 32'hA5C3_1234); bus_read(8'h3C, r); check("R2 spacing rw", r, 32'hA5C3_1234);
      bus_write(8'h38, 32'hFFFF_FFFE); bus_read(8'h38, r); check("R2 select bit0 only", r, 32'h0);
      bus_write(8'h04, 32'h1357_9BDF); bus_read(8'h04, r); check("R2 cmd rw", r, 32'h1357_9BDF);
      bus_write(8'h00, 32'h0000_0035); bus_read(8'h00, r); check("R2 ctrl rw", r, 32'h0000_0035);

      // R11 select
      bus_write(8'h38, 32'h1);
      check("R11 ss asserted", {31'b0, spi_ss}, 32'd0);

      // R10 zero counts
      rises = 0;
      bus_write(8'h00, 32'h0000_0100);
      bus_read(8'h00, r); check("R10 busy set", {31'b0, r[16]}, 32'd1);
      @(negedge clk);
      bus_read(8'h00, r); check("R10 busy one cycle", {31'b0, r[16]}, 32'd0);
      check("R10 no sck edge", 32'(rises), 32'd0);

      // directed transfers: full both ways, minimum ratio, odd ratio
      run_xact(32'h8899_AABB, 32'h4433_2211, 8, 8, 0, 1'b0);
      run_xact(32'h0102_0304, 32'hCAFE_F00D, 3, 5, 3, 1'b0);
      run_xact(32'h5566_7788, 32'h99AA_BBCC, 4, 0, 2, 1'b0);  // R13
      run_xact(32'h0F1E_2D3C, 32'h4B5A_6978, 0, 3, 1, 1'b0);
      run_xact(32'h7777_1111, 32'h2222_3333, 12, 15, 0, 1'b0); // R8 clamp
      run_xact(32'h1234_5678, 32'h9ABC_DEF0, 2, 2, 3, 1'b1);   // R9 R12
      check("R11 ss held", {31'b0, spi_ss}, 32'd0);

      // constrained random
      for (int k = 0; k < 24; k++)
         run_xact($urandom, $urandom, int'($urandom % 9), int'($urandom % 9),
                  int'($urandom % 5), 1'b0);

      bus_write(8'h38, 32'h0);
      check("R11 ss released", {31'b0, spi_ss}, 32'd1);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule